// File: doc/BRIEF.md
# Sixteen-Opcode Data-Processing ALU

This block is the integer data-processing unit of a 32-bit processor execute stage. It is purely combinational. A 4-bit opcode selects one of sixteen operations on a first operand and a second operand. The second operand is either a value that an external shifter has already produced, together with that shifter's carry-out, or an immediate built inside the block. The immediate is an 8-bit constant rotated right by twice a 4-bit rotate count.

The block returns the result, a write enable for the destination register, and a new set of N, Z, C and V flags. The current flags come in on a 4-bit bus, and the carry among them feeds the carry-chained operations. Flags are updated when the caller asks for it. The four compare/test opcodes always update the flags and never write a result. When no update applies, the outgoing flags equal the incoming ones.

Top module: `dp_alu`

## Requirements
- R1: Logical and move opcodes give: 0 = rn & op2, 1 = rn ^ op2, 12 = rn | op2, 13 = op2, 14 = rn & ~op2, 15 = ~op2.
- R2: Forward arithmetic gives: 2 = rn - op2, 4 = rn + op2, 5 = rn + op2 + C, 6 = rn - op2 - (1 - C). C is flags_in[1].
- R3: Reverse arithmetic gives: 3 = op2 - rn, 7 = op2 - rn - (1 - C).
- R4: Opcodes 8, 9, 10 and 11 compute AND, XOR, subtract and add on result. They hold wr_en low and update flags_out whatever set_flags is.
- R5: wr_en is high for every opcode outside 8 to 11.
- R6: When set_flags is low and the opcode is outside 8 to 11, flags_out equals flags_in. The flag bus layout is bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R7: On a flag update, N is result bit 31 and Z is set exactly when result is zero.
- R8: On an arithmetic flag update, C is the carry out for add forms and the absence of a borrow for subtract forms. V is set on two's-complement overflow of the operation in its own operand order.
- R9: On a logical flag update (opcodes 0, 1, 8, 9, 12 to 15), C is the shifter carry and V keeps flags_in[0].
- R10: With use_imm high, op2 is imm zero-extended and rotated right by 2*rot bits, and op2_in is ignored.
- R11: With use_imm high, the shifter carry is bit 31 of the rotated immediate when rot is nonzero and flags_in[1] when rot is zero. With use_imm low, it is sh_carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | operation select |
| rn | input | 32 | first operand |
| op2_in | input | 32 | shifted second operand |
| sh_carry | input | 1 | carry-out of the external shifter |
| use_imm | input | 1 | take the rotated immediate as second operand |
| imm | input | 8 | immediate constant |
| rot | input | 4 | rotate count, halved |
| set_flags | input | 1 | request a flag update |
| flags_in | input | 4 | current N,Z,C,V |
| result | output | 32 | operation result |
| wr_en | output | 1 | destination write enable |
| flags_out | output | 4 | next N,Z,C,V |

## Verification
Every output of this block is due in the same cycle as the stimulus, since no register lies between any input and any output. The bench changes inputs just after a rising clock edge and compares result, wr_en and flags_out at the following falling edge, half a period later. A wide-integer reference model sweeps all sixteen opcodes over both carry values against operand pairs chosen to overflow, borrow and produce zero. Hand-computed vectors and rotated-immediate cases come after the sweep.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W     = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [3:0]       opcode,
  input  logic [W-1:0]     rn,
  input  logic [W-1:0]     op2_in,
  input  logic             sh_carry,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             set_flags,
  input  logic [3:0]       flags_in,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic [3:0]       flags_out
);
  localparam int AMT_W = ROT_W + 1;

  logic [AMT_W-1:0] amt;
  logic [W-1:0]     imm_ext, imm_rot, op2;
  logic [2*W-1:0]   imm_dbl;
  logic             shc, cin;

  assign amt     = {rot, 1'b0};
  assign imm_ext = W'(imm);
  assign imm_dbl = {imm_ext, imm_ext} >> amt;
  assign imm_rot = imm_dbl[W-1:0];
  assign op2     = use_imm ? imm_rot : op2_in;
  assign shc     = use_imm ? ((rot != '0) ? imm_rot[W-1] : flags_in[1]) : sh_carry;
  assign cin     = flags_in[1];

  logic [W-1:0] add_a, add_b, logic_res;
  logic         add_ci, is_arith;
  logic [W:0]   sum;

  always_comb begin
    add_a    = rn;
    add_b    = op2;
    add_ci   = 1'b0;
    is_arith = 1'b1;
    unique case (opcode)
      4'h2, 4'hA: begin add_b = ~op2; add_ci = 1'b1; end
      4'h6:       begin add_b = ~op2; add_ci = cin;  end
      4'h3:       begin add_a = op2; add_b = ~rn; add_ci = 1'b1; end
      4'h7:       begin add_a = op2; add_b = ~rn; add_ci = cin;  end
      4'h4, 4'hB: add_ci = 1'b0;
      4'h5:       add_ci = cin;
      default:    is_arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, add_a} + {1'b0, add_b} + (W+1)'(add_ci);

  always_comb begin
    unique case (opcode)
      4'h0, 4'h8: logic_res = rn & op2;
      4'h1, 4'h9: logic_res = rn ^ op2;
      4'hC:       logic_res = rn | op2;
      4'hD:       logic_res = op2;
      4'hE:       logic_res = rn & ~op2;
      default:    logic_res = ~op2;
    endcase
  end

  logic is_cmp, upd, c_new, v_new;

  assign result = is_arith ? sum[W-1:0] : logic_res;
  assign is_cmp = (opcode[3:2] == 2'b10);
  assign wr_en  = !is_cmp;
  assign upd    = set_flags || is_cmp;
  assign c_new  = is_arith ? sum[W] : shc;
  assign v_new  = is_arith ? ((add_a[W-1] == add_b[W-1]) && (sum[W-1] != add_a[W-1]))
                           : flags_in[0];
  assign flags_out = upd ? {result[W-1], result == '0, c_new, v_new} : flags_in;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int W = 32
) (
  input logic [3:0]   opcode,
  input logic         set_flags,
  input logic [3:0]   flags_in,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   flags_out
);
  logic cmp_op, logical_op;
  assign cmp_op     = opcode inside {4'h8, 4'h9, 4'hA, 4'hB};
  assign logical_op = opcode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF};

  always_comb begin
    a_r4_cmp_no_write: assert (!cmp_op || !wr_en);
    a_r5_write_other: assert (cmp_op || wr_en);
    a_r6_flags_hold: assert (cmp_op || set_flags || flags_out == flags_in);
    a_r7_nz_from_result: assert (!(cmp_op || set_flags) ||
                                 (flags_out[3] == result[W-1] && flags_out[2] == (result == '0)));
    a_r9_logic_keeps_v: assert (!logical_op || flags_out[0] == flags_in[0]);
  end
endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
  .opcode(opcode), .set_flags(set_flags), .flags_in(flags_in),
  .result(result), .wr_en(wr_en), .flags_out(flags_out)
);

// File: tb/test_dp_alu.sv
module test_dp_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = '0;
  logic [31:0] rn = '0, op2_in = '0;
  logic        sh_carry = 1'b0, use_imm = 1'b0, set_flags = 1'b0;
  logic [7:0]  imm = '0;
  logic [3:0]  rot = '0, flags_in = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  dp_alu i_dp_alu (
    .opcode(opcode), .rn(rn), .op2_in(op2_in), .sh_carry(sh_carry),
    .use_imm(use_imm), .imm(imm), .rot(rot), .set_flags(set_flags),
    .flags_in(flags_in), .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  localparam logic [63:0] PAIRS [8] = '{
    {32'h00000000, 32'h00000000}, {32'h7fffffff, 32'h00000001},
    {32'h80000000, 32'h80000000}, {32'hffffffff, 32'h00000001},
    {32'h00000005, 32'h00000003}, {32'h00000003, 32'h00000005},
    {32'h12345678, 32'hf0f0f0f0}, {32'h80000000, 32'h00000001}
  };

  // {opcode, rn, op2, flags_in, expected result, expected flags}
  localparam logic [107:0] HAND [7] = '{
    {4'h4, 32'h7fffffff, 32'h00000001, 4'b0000, 32'h80000000, 4'b1001},
    {4'h2, 32'h00000000, 32'h00000001, 4'b0000, 32'hffffffff, 4'b1000},
    {4'h3, 32'h00000005, 32'h00000003, 4'b0000, 32'hfffffffe, 4'b1000},
    {4'h6, 32'h00000005, 32'h00000003, 4'b0000, 32'h00000001, 4'b0010},
    {4'h7, 32'h00000001, 32'h80000000, 4'b0010, 32'h7fffffff, 4'b0011},
    {4'hA, 32'h00000003, 32'h00000003, 4'b0000, 32'h00000000, 4'b0110},
    {4'h5, 32'hffffffff, 32'h00000000, 4'b0010, 32'h00000000, 4'b0110}
  };

  function automatic void ref_model(
    input logic [3:0] op, input logic [31:0] a, input logic [31:0] b_in,
    input logic shc_in, input logic ui, input logic [7:0] im, input logic [3:0] rt,
    input logic sf, input logic [3:0] fi,
    output logic [31:0] r, output logic w, output logic [3:0] f);
    logic [31:0] b, iv;
    logic shc, c, v, arith;
    longint ua, ub, sa, sb, us, ss;
    int n;
    n = 2 * int'(rt);
    iv = 32'(im);
    if (ui) begin
      b = (n == 0) ? iv : ((iv >> n) | (iv << (32 - n)));
      shc = (n == 0) ? fi[1] : b[31];
    end else begin
      b = b_in;
      shc = shc_in;
    end
    arith = 1'b1;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    us = 0; ss = 0;
    case (op)
      4'h2, 4'hA: begin us = ua - ub;                      ss = sa - sb; end
      4'h6:       begin us = ua - ub - longint'(!fi[1]);   ss = sa - sb - longint'(!fi[1]); end
      4'h3:       begin us = ub - ua;                      ss = sb - sa; end
      4'h7:       begin us = ub - ua - longint'(!fi[1]);   ss = sb - sa - longint'(!fi[1]); end
      4'h4, 4'hB: begin us = ua + ub;                      ss = sa + sb; end
      4'h5:       begin us = ua + ub + longint'(fi[1]);    ss = sa + sb + longint'(fi[1]); end
      default:    arith = 1'b0;
    endcase
    if (arith) begin
      r = us[31:0];
      if (op inside {4'h4, 4'h5, 4'hB}) c = (us > 64'sd4294967295);
      else c = (us >= 0);
      v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    end else begin
      case (op)
        4'h0, 4'h8: r = a & b;
        4'h1, 4'h9: r = a ^ b;
        4'hC:       r = a | b;
        4'hD:       r = b;
        4'hE:       r = a & ~b;
        default:    r = ~b;
      endcase
      c = shc;
      v = fi[0];
    end
    w = !(op inside {4'h8, 4'h9, 4'hA, 4'hB});
    f = (sf || !w) ? {r[31], r == 32'h0, c, v} : fi;
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic ew, input logic [3:0] ef);
    checks++;
    if (result !== er || wr_en !== ew || flags_out !== ef) begin
      failures++;
      $display("FAIL %s op=%h res=%h/%h wr=%b/%b flags=%b/%b (actual/expected)",
               req, opcode, result, er, wr_en, ew, flags_out, ef);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic ui, input logic [7:0] im, input logic [3:0] rt,
                       input logic sf, input logic [3:0] fi);
    @(posedge clk);
    #1;
    opcode = op; rn = a; op2_in = b; sh_carry = sc; use_imm = ui;
    imm = im; rot = rt; set_flags = sf; flags_in = fi;
    @(negedge clk);
  endtask

  task automatic run_ref(input string req, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic sc, input logic ui, input logic [7:0] im,
                         input logic [3:0] rt, input logic sf, input logic [3:0] fi);
    logic [31:0] er; logic ew; logic [3:0] ef;
    drive(op, a, b, sc, ui, im, rt, sf, fi);
    ref_model(op, a, b, sc, ui, im, rt, sf, fi, er, ew, ef);
    check(req, er, ew, ef);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs select AND of zeros, writes, flags held
    @(negedge clk);
    check("R5 reset", 32'h0, 1'b1, 4'b0000);

    // sweep: R1 R2 R3 R4 R5 R7 R8 R9
    for (int p = 0; p < 8; p++)
      for (int op = 0; op < 16; op++)
        for (int cf = 0; cf < 2; cf++)
          run_ref("R1/R2/R3/R4/R8 sweep", 4'(op), PAIRS[p][63:32], PAIRS[p][31:0],
                  1'(p & 1), 1'b0, 8'h0, 4'h0, 1'b1, {2'b01, 1'(cf), 1'(p & 1)});

    // hand-computed arithmetic vectors: R2 R3 R4 R8
    for (int h = 0; h < 7; h++) begin
      drive(HAND[h][107:104], HAND[h][103:72], HAND[h][71:40], 1'b0, 1'b0, 8'h0, 4'h0,
            1'b1, HAND[h][39:36]);
      check("R8 hand", HAND[h][35:4], !(HAND[h][107:104] inside {4'h8, 4'h9, 4'hA, 4'hB}),
            HAND[h][3:0]);
    end

    // R6: no update request keeps flags, compares still update (R4)
    drive(4'h4, 32'hffffffff, 32'h1, 1'b0, 1'b0, 8'h0, 4'h0, 1'b0, 4'b1001);
    check("R6 hold", 32'h0, 1'b1, 4'b1001);
    drive(4'hB, 32'hffffffff, 32'h1, 1'b0, 1'b0, 8'h0, 4'h0, 1'b0, 4'b1001);
    check("R4 cmn updates", 32'h0, 1'b0, 4'b0110);

    // R9: logical takes shifter carry, keeps V
    drive(4'h0, 32'h0, 32'hffffffff, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, 4'b0001);
    check("R9 logic carry", 32'h0, 1'b1, 4'b0111);

    // R10/R11: rotated immediate
    drive(4'hD, 32'h0, 32'h12345678, 1'b0, 1'b1, 8'hFF, 4'h4, 1'b1, 4'b0000);
    check("R10 R11 imm ror8", 32'hFF000000, 1'b1, 4'b1010);
    drive(4'hD, 32'h0, 32'h12345678, 1'b0, 1'b1, 8'h03, 4'h1, 1'b1, 4'b0000);
    check("R10 R11 imm ror2", 32'hC0000000, 1'b1, 4'b1010);
    drive(4'hD, 32'h0, 32'h12345678, 1'b0, 1'b1, 8'h80, 4'h0, 1'b1, 4'b0010);
    check("R11 rot zero keeps C", 32'h00000080, 1'b1, 4'b0010);
    drive(4'hD, 32'h0, 32'h12345678, 1'b1, 1'b1, 8'h80, 4'h0, 1'b1, 4'b0000);
    check("R11 rot zero ignores sh_carry", 32'h00000080, 1'b1, 4'b0000);
    for (int r = 0; r < 16; r++)
      run_ref("R10 imm sweep", 4'h4, 32'h11111111, 32'hdeadbeef, 1'b0, 1'b1, 8'hA5, 4'(r),
              1'b1, 4'b0010);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule